// File: doc/BRIEF.md
# Indirect-Select Interrupt Configuration Unit

This block manages a parameterised set of interrupt lines. Software reaches it through a narrow register bus. It first writes a line number into a select register. Every later access to the per-line registers (enable, priority, trigger mode, pending cancel) then acts on that line alone, until the select value is changed. Each line holds an enable bit, a 4-bit priority with a separate secure flag, and a trigger mode that is either level or pulse.

Level lines are pending for as long as their registered input is high. Pulse lines latch a rising edge into a pending bit. That bit is cleared when the line's handler is entered, or when software writes the cancel register. An arbiter picks the most urgent line that is both pending and enabled. The block raises a request only when that line would preempt every line already in service. The processor acknowledges a request to mark the line active and reports handler exit by line number. A status register shows which lines are in service.

Top module: `irq_select_unit`

## Requirements
- R1: After reset, every line is disabled, level-triggered, at priority 0xF with the secure flag clear. The select register reads 0, no line is pending or active, and `irq_req` is low.
- R2: Register offsets 1 to 4 act only on the line whose number was last written to offset 0, the select register. Select holds 8 bits and reads back its value. While select is N_LINES or above, per-line writes change nothing and per-line reads return 0.
- R3: Offset 1 is the enable register. Bit 0 of a write enables (1) or disables (0) the selected line, and a read returns that state in bit 0.
- R4: Offset 2 is the priority register. A write stores bits [3:0] as the priority and bit 8 as the secure flag. A read returns those two fields in the same positions, with every other bit 0.
- R5: Offset 3 is the trigger register. Bit 0 selects level (0) or pulse (1) mode, and a read returns the mode.
- R6: A level line is pending for as long as its input is high, one clock after the input is sampled. Acknowledging the line does not clear it; only the input falling does.
- R7: A pulse line latches pending on a rising edge of its input. An input held high does not latch again. Acknowledging the line clears the latch.
- R8: Writing offset 4 with bit 0 set clears the latched pulse pending of the selected line, and a write with bit 0 clear does nothing. A rising edge in the same cycle as a cancel or an acknowledge wins, so the latch stays set.
- R9: Among lines that are pending and enabled, the lowest priority number wins, and a tie goes to the lower line number. A disabled line is never requested.
- R10: `irq_req` is high only when the winner's priority is numerically below the priority of every active line.
- R11: `irq_ack` while `irq_req` is high marks the reported line active, and `irq_ack` without a request is ignored. `irq_done` with `irq_done_id` clears that line's active bit.
- R12: Offset 5 reads the active lines, with bit i for line i and all higher bits 0. `in_handler` is high whenever any line is active.
- R13: Offsets 6 and 7 read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lines | input | N_LINES | Interrupt inputs from peripherals |
| irq_ack | input | 1 | Handler entry for the line on `irq_req_id` |
| irq_done | input | 1 | Handler exit strobe |
| irq_done_id | input | clog2(N_LINES) | Line whose handler exits |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_req_id | output | clog2(N_LINES) | Winning line number |
| irq_req_prio | output | 4 | Winning line's priority |
| in_handler | output | 1 | Any line is in service |

## Verification
Two functions can hit the same pulse latch in one cycle: setting it from a fresh input edge and clearing it by a cancel write. The bench raises a line's input on a falling clock edge. It waits for the next rising edge, which makes the edge detector true. It then issues the cancel write, so that cancel and edge are sampled at the same rising edge. The bench judges the outcome at the ports: `irq_req` must stay high for that line, and a later cancel with the input still held high must clear it, because a held input does not count as a second edge.

// File: rtl/icu_pkg.sv
package icu_pkg;

    localparam int PRIO_W  = 4;
    localparam int SEL_W   = 8;
    localparam int SEC_BIT = 8;
    localparam int BUS_AW  = 3;
    localparam int BUS_DW  = 32;
    localparam int ACT_W   = 16;

    typedef enum logic [BUS_AW-1:0] {
        A_SEL    = 3'd0,
        A_EN     = 3'd1,
        A_PRIO   = 3'd2,
        A_TRIG   = 3'd3,
        A_CANCEL = 3'd4,
        A_ACT    = 3'd5
    } reg_addr_e;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_PULSE = 1'b1
    } trig_e;

    typedef struct packed {
        logic              en;
        logic              secure;
        logic [PRIO_W-1:0] prio;
        trig_e             trig;
    } line_cfg_t;

    localparam line_cfg_t CFG_RESET = '{en: 1'b0, secure: 1'b0, prio: 4'hF, trig: TRIG_LEVEL};

    function automatic logic [BUS_DW-1:0] pack_prio(line_cfg_t c);
        logic [BUS_DW-1:0] r;
        r = '0;
        r[PRIO_W-1:0] = c.prio;
        r[SEC_BIT]    = c.secure;
        return r;
    endfunction

    function automatic line_cfg_t apply_prio(line_cfg_t c, logic [BUS_DW-1:0] d);
        line_cfg_t r;
        r        = c;
        r.prio   = d[PRIO_W-1:0];
        r.secure = d[SEC_BIT];
        return r;
    endfunction

endpackage

// File: rtl/icu_regfile.sv
module icu_regfile
    import icu_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int ID_W = $clog2(N_LINES)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bus_wen,
    input  logic [BUS_AW-1:0]         bus_addr,
    input  logic [BUS_DW-1:0]         bus_wdata,
    output logic [BUS_DW-1:0]         bus_rdata,
    input  logic [N_LINES-1:0]        active_vec,
    output line_cfg_t [N_LINES-1:0]   cfg_o,
    output logic [N_LINES-1:0]        cancel_o
);

    logic [SEL_W-1:0]        sel_q;
    line_cfg_t [N_LINES-1:0] cfg_q;
    logic                    sel_ok;
    logic [ID_W-1:0]         sel_id;
    reg_addr_e               addr;
    logic [N_LINES-1:0]      hit;
    logic                    unused_wdata;

    assign addr         = reg_addr_e'(bus_addr);
    assign sel_ok       = (sel_q < SEL_W'(N_LINES));
    assign sel_id       = sel_q[ID_W-1:0];
    assign unused_wdata = ^bus_wdata[BUS_DW-1:SEC_BIT+1];

    // one write-hit strobe per line, decoded from the shared select
    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_hit
        assign hit[gi]      = bus_wen && sel_ok && (sel_id == ID_W'(gi));
        assign cancel_o[gi] = hit[gi] && (addr == A_CANCEL) && bus_wdata[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (bus_wen && addr == A_SEL) begin
            sel_q <= bus_wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_LINES; i++) cfg_q[i] <= CFG_RESET;
        end else begin
            for (int i = 0; i < N_LINES; i++) begin
                if (hit[i]) begin
                    case (addr)
                        A_EN:    cfg_q[i].en   <= bus_wdata[0];
                        A_PRIO:  cfg_q[i]      <= apply_prio(cfg_q[i], bus_wdata);
                        A_TRIG:  cfg_q[i].trig <= trig_e'(bus_wdata[0]);
                        default: ;
                    endcase
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (addr)
            A_SEL:  bus_rdata = BUS_DW'(sel_q);
            A_EN:   if (sel_ok) bus_rdata = BUS_DW'(cfg_q[sel_id].en);
            A_PRIO: if (sel_ok) bus_rdata = pack_prio(cfg_q[sel_id]);
            A_TRIG: if (sel_ok) bus_rdata = BUS_DW'(cfg_q[sel_id].trig);
            A_ACT:  bus_rdata = BUS_DW'(active_vec);
            default: bus_rdata = '0;
        endcase
    end

    assign cfg_o = cfg_q;

    AST_SEL_OOR_HOLD: assert property (@(posedge clk) disable iff (rst) (bus_wen && !sel_ok && addr != A_SEL) |=> $stable(cfg_q)); // R2
    AST_UNIMPL_HOLD: assert property (@(posedge clk) disable iff (rst) (bus_wen && bus_addr > 3'd5) |=> ($stable(cfg_q) && $stable(sel_q))); // R13

endmodule

// File: rtl/icu_pending.sv
module icu_pending
    import icu_pkg::*;
#(
    parameter int N_LINES = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic [N_LINES-1:0] pulse_mode,
    input  logic [N_LINES-1:0] cancel,
    input  logic [N_LINES-1:0] ack_clr,
    output logic [N_LINES-1:0] pend_o
);

    logic [N_LINES-1:0] sync_q;
    logic [N_LINES-1:0] prev_q;
    logic [N_LINES-1:0] pulse_q;
    logic [N_LINES-1:0] rise;

    assign rise = sync_q & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            sync_q <= irq_lines;
            prev_q <= sync_q;
        end
    end

    // a fresh edge outranks any clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= '0;
        end else begin
            for (int i = 0; i < N_LINES; i++) begin
                if (!pulse_mode[i])               pulse_q[i] <= 1'b0;
                else if (rise[i])                 pulse_q[i] <= 1'b1;
                else if (cancel[i] || ack_clr[i]) pulse_q[i] <= 1'b0;
            end
        end
    end

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_line
        assign pend_o[gi] = pulse_mode[gi] ? pulse_q[gi] : sync_q[gi];

        AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst) (rise[gi] && pulse_mode[gi]) |=> pulse_q[gi]); // R8
        AST_CANCEL_CLEARS: assert property (@(posedge clk) disable iff (rst) (cancel[gi] && !rise[gi]) |=> !pulse_q[gi]); // R8
        AST_ACK_CLEARS_PULSE: assert property (@(posedge clk) disable iff (rst) (ack_clr[gi] && !rise[gi]) |=> !pulse_q[gi]); // R7
    end

endmodule

// File: rtl/icu_arbiter.sv
module icu_arbiter
    import icu_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int ID_W = $clog2(N_LINES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [N_LINES-1:0]              elig,
    input  logic [N_LINES-1:0][PRIO_W-1:0]  prio_vec,
    output logic                            win_valid,
    output logic [ID_W-1:0]                 win_id,
    output logic [PRIO_W-1:0]               win_prio
);

    // strict less-than keeps the lower index on a tie
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_prio  = '1;
        for (int i = 0; i < N_LINES; i++) begin
            if (elig[i] && (!win_valid || prio_vec[i] < win_prio)) begin
                win_valid = 1'b1;
                win_id    = ID_W'(i);
                win_prio  = prio_vec[i];
            end
        end
    end

    AST_WIN_ELIGIBLE: assert property (@(posedge clk) disable iff (rst) win_valid |-> elig[win_id]); // R9
    AST_WIN_IFF_ANY: assert property (@(posedge clk) disable iff (rst) (|elig) |-> win_valid); // R9

endmodule

// File: rtl/icu_active.sv
module icu_active
    import icu_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int ID_W = $clog2(N_LINES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            ack_take,
    input  logic [ID_W-1:0]                 ack_id,
    input  logic                            done_valid,
    input  logic [ID_W-1:0]                 done_id,
    input  logic [N_LINES-1:0][PRIO_W-1:0]  prio_vec,
    output logic [N_LINES-1:0]              active_o,
    output logic [PRIO_W:0]                 min_prio_o
);

    logic [N_LINES-1:0] act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
        end else begin
            for (int i = 0; i < N_LINES; i++) begin
                if (ack_take && ack_id == ID_W'(i))          act_q[i] <= 1'b1;
                else if (done_valid && done_id == ID_W'(i))  act_q[i] <= 1'b0;
            end
        end
    end

    // one above the largest priority when nothing is in service
    always_comb begin
        min_prio_o = {1'b1, {PRIO_W{1'b0}}};
        for (int i = 0; i < N_LINES; i++) begin
            if (act_q[i] && {1'b0, prio_vec[i]} < min_prio_o) min_prio_o = {1'b0, prio_vec[i]};
        end
    end

    assign active_o = act_q;

    AST_ACT_SET: assert property (@(posedge clk) disable iff (rst) ack_take |=> act_q[$past(ack_id)]); // R11
    AST_ACT_CLEAR: assert property (@(posedge clk) disable iff (rst) (done_valid && !(ack_take && ack_id == done_id)) |=> !act_q[$past(done_id)]); // R11

endmodule

// File: rtl/irq_select_unit.sv
module irq_select_unit
    import icu_pkg::*;
#(
    parameter int N_LINES = 8,
    localparam int ID_W = $clog2(N_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wen,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    output logic [BUS_DW-1:0]    bus_rdata,
    input  logic [N_LINES-1:0]   irq_lines,
    input  logic                 irq_ack,
    input  logic                 irq_done,
    input  logic [ID_W-1:0]      irq_done_id,
    output logic                 irq_req,
    output logic [ID_W-1:0]      irq_req_id,
    output logic [PRIO_W-1:0]    irq_req_prio,
    output logic                 in_handler
);

    // N_LINES is expected between 2 and ACT_W so the status word fits

    line_cfg_t [N_LINES-1:0]            cfg;
    logic [N_LINES-1:0][PRIO_W-1:0]     prio_vec;
    logic [N_LINES-1:0]                 pulse_mode;
    logic [N_LINES-1:0]                 enable_vec;
    logic [N_LINES-1:0]                 cancel;
    logic [N_LINES-1:0]                 ack_clr;
    logic [N_LINES-1:0]                 pend;
    logic [N_LINES-1:0]                 elig;
    logic [N_LINES-1:0]                 active;
    logic                               win_valid;
    logic [ID_W-1:0]                    win_id;
    logic [PRIO_W-1:0]                  win_prio;
    logic [PRIO_W:0]                    min_act;
    logic                               ack_take;

    for (genvar gi = 0; gi < N_LINES; gi++) begin : g_fan
        assign prio_vec[gi]   = cfg[gi].prio;
        assign pulse_mode[gi] = (cfg[gi].trig == TRIG_PULSE);
        assign enable_vec[gi] = cfg[gi].en;
        assign ack_clr[gi]    = ack_take && (win_id == ID_W'(gi));
    end

    assign elig     = pend & enable_vec;
    assign irq_req  = win_valid && ({1'b0, win_prio} < min_act);
    assign ack_take = irq_ack && irq_req;

    icu_regfile #(.N_LINES(N_LINES)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .bus_wen    (bus_wen),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .active_vec (active),
        .cfg_o      (cfg),
        .cancel_o   (cancel)
    );

    icu_pending #(.N_LINES(N_LINES)) u_pend (
        .clk        (clk),
        .rst        (rst),
        .irq_lines  (irq_lines),
        .pulse_mode (pulse_mode),
        .cancel     (cancel),
        .ack_clr    (ack_clr),
        .pend_o     (pend)
    );

    icu_arbiter #(.N_LINES(N_LINES)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .elig      (elig),
        .prio_vec  (prio_vec),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_prio  (win_prio)
    );

    icu_active #(.N_LINES(N_LINES)) u_act (
        .clk        (clk),
        .rst        (rst),
        .ack_take   (ack_take),
        .ack_id     (win_id),
        .done_valid (irq_done),
        .done_id    (irq_done_id),
        .prio_vec   (prio_vec),
        .active_o   (active),
        .min_prio_o (min_act)
    );

    assign irq_req_id   = win_id;
    assign irq_req_prio = win_prio;
    assign in_handler   = |active;

    AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (rst) irq_req |-> cfg[irq_req_id].en); // R9
    AST_REQ_PENDING: assert property (@(posedge clk) disable iff (rst) irq_req |-> pend[irq_req_id]); // R6
    AST_REQ_NOT_ACTIVE: assert property (@(posedge clk) disable iff (rst) irq_req |-> !active[irq_req_id]); // R10
    AST_NO_ACK_NO_CHANGE: assert property (@(posedge clk) disable iff (rst) (irq_ack && !irq_req && !irq_done) |=> $stable(active)); // R11

endmodule

// File: tb/irq_select_unit_test.sv
module irq_select_unit_test;
    import icu_pkg::*;

    localparam int N   = 8;
    localparam int IDW = 3;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_wen = 1'b0;
    logic [2:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [N-1:0]   irq_lines = '0;
    logic           irq_ack = 1'b0;
    logic           irq_done = 1'b0;
    logic [IDW-1:0] irq_done_id = '0;
    logic           irq_req;
    logic [IDW-1:0] irq_req_id;
    logic [3:0]     irq_req_prio;
    logic           in_handler;

    always #5 clk = ~clk;

    irq_select_unit #(.N_LINES(N)) uut (
        .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
        .irq_ack(irq_ack), .irq_done(irq_done), .irq_done_id(irq_done_id),
        .irq_req(irq_req), .irq_req_id(irq_req_id), .irq_req_prio(irq_req_prio),
        .in_handler(in_handler)
    );

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_val_q[$];
    int          exp_kind_q[$];
    string       exp_msg_q[$];
    logic        strobe = 1'b0;
    bit          finished = 1'b0;

    // kind 0: read data, 1: {req, prio, id}, 2: in_handler
    function automatic logic [31:0] observe(int kind);
        case (kind)
            0:       return bus_rdata;
            1:       return 32'({irq_req, irq_req_prio, irq_req_id});
            default: return 32'(in_handler);
        endcase
    endfunction

    // monitor: pops the scoreboard in the middle of the low phase
    initial forever begin
        @(negedge clk);
        #3;
        if (strobe && exp_val_q.size() > 0) begin
            logic [31:0] e, a, m;
            int k;
            string s;
            e = exp_val_q.pop_front();
            k = exp_kind_q.pop_front();
            s = exp_msg_q.pop_front();
            a = observe(k);
            m = (k == 1 && !e[7]) ? 32'h80 : 32'hFFFF_FFFF;
            checks++;
            if ((a & m) != (e & m)) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", s, a & m, e & m);
            end
        end
    end

    task automatic expect_obs(int kind, logic [31:0] v, string msg, logic [2:0] addr);
        @(negedge clk);
        bus_addr = addr;
        exp_val_q.push_back(v);
        exp_kind_q.push_back(kind);
        exp_msg_q.push_back(msg);
        strobe = 1'b1;
        @(posedge clk);
        #1 strobe = 1'b0;
    endtask

    task automatic rd(logic [2:0] addr, logic [31:0] v, string msg);
        expect_obs(0, v, msg, addr);
    endtask

    task automatic req_is(logic r, logic [IDW-1:0] id, logic [3:0] p, string msg);
        expect_obs(1, 32'({r, p, id}), msg, 3'd0);
    endtask

    task automatic wr(logic [2:0] addr, logic [31:0] d);
        @(negedge clk);
        bus_wen = 1'b1; bus_addr = addr; bus_wdata = d;
        @(posedge clk);
        #1 bus_wen = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic set_line(int i, logic v);
        @(negedge clk);
        irq_lines[i] = v;
    endtask

    task automatic do_ack();
        @(negedge clk);
        irq_ack = 1'b1;
        @(posedge clk);
        #1 irq_ack = 1'b0;
    endtask

    task automatic do_done(logic [IDW-1:0] id);
        @(negedge clk);
        irq_done = 1'b1; irq_done_id = id;
        @(posedge clk);
        #1 irq_done = 1'b0;
    endtask

    task automatic pulse_line(int i);
        set_line(i, 1'b1);
        idle(2);
        set_line(i, 1'b0);
        idle(2);
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(3'd0, 32'h0, "R1 select");
        rd(3'd1, 32'h0, "R1 enable");
        rd(3'd2, 32'hF, "R1 priority");
        rd(3'd3, 32'h0, "R1 trigger");
        rd(3'd5, 32'h0, "R1 active");
        req_is(1'b0, 0, 0, "R1 no request");
        expect_obs(2, 32'h0, "R1 in_handler", 3'd0);

        // R3 R4 on line 3, R2 redirection
        wr(3'd0, 32'd3);
        wr(3'd1, 32'h1);
        wr(3'd2, 32'hFFFF_F1A7);
        rd(3'd2, 32'h107, "R4 prio and secure fields");
        rd(3'd1, 32'h1, "R3 enable readback");
        wr(3'd0, 32'd2);
        rd(3'd1, 32'h0, "R2 other line untouched");
        wr(3'd0, 32'd3);
        rd(3'd1, 32'h1, "R2 reselect line 3");

        // R2 out-of-range select
        wr(3'd0, 32'd9);
        rd(3'd0, 32'd9, "R2 select readback");
        wr(3'd1, 32'h1);
        wr(3'd2, 32'h0);
        rd(3'd1, 32'h0, "R2 oor enable read");
        rd(3'd2, 32'h0, "R2 oor prio read");
        wr(3'd0, 32'd2);
        rd(3'd1, 32'h0, "R2 oor write ignored enable");
        rd(3'd2, 32'hF, "R2 oor write ignored prio");

        // R13 unimplemented offsets
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd6, 32'h0, "R13 offset 6");
        rd(3'd7, 32'h0, "R13 offset 7");
        rd(3'd2, 32'hF, "R13 no state change");
        rd(3'd0, 32'd2, "R13 select kept");

        // R6 level line 3 (prio 7)
        set_line(3, 1'b1);
        idle(1);
        req_is(1'b1, 3, 7, "R6 level pending");
        do_ack();
        rd(3'd5, 32'h08, "R12 active word");
        expect_obs(2, 32'h1, "R12 in_handler", 3'd0);
        req_is(1'b0, 0, 0, "R10 equal priority blocked");
        do_done(3);
        req_is(1'b1, 3, 7, "R6 ack keeps level");
        set_line(3, 1'b0);
        idle(1);
        req_is(1'b0, 0, 0, "R6 input falls");

        // R5 R7 pulse line 5 (prio 2)
        wr(3'd0, 32'd5);
        wr(3'd1, 32'h1);
        wr(3'd2, 32'h2);
        wr(3'd3, 32'h1);
        rd(3'd3, 32'h1, "R5 trigger readback");
        pulse_line(5);
        req_is(1'b1, 5, 2, "R7 pulse latched");
        set_line(3, 1'b1);
        idle(2);
        req_is(1'b1, 5, 2, "R9 lower number wins");
        do_ack();
        rd(3'd5, 32'h20, "R11 ack marks line 5");
        req_is(1'b0, 0, 0, "R10 line 3 cannot preempt");
        do_done(5);
        idle(1);
        req_is(1'b1, 3, 7, "R7 ack cleared pulse latch");

        // R9 tie and disabled line
        wr(3'd0, 32'd1);
        wr(3'd1, 32'h1);
        wr(3'd2, 32'h7);
        set_line(1, 1'b1);
        idle(2);
        req_is(1'b1, 1, 7, "R9 tie to lower line");
        wr(3'd0, 32'd0);
        wr(3'd2, 32'h0);
        set_line(0, 1'b1);
        idle(2);
        req_is(1'b1, 1, 7, "R9 disabled line ignored");

        // R10 nesting
        do_ack();
        rd(3'd5, 32'h02, "R11 line 1 active");
        req_is(1'b0, 0, 0, "R10 blocked by active");
        pulse_line(5);
        req_is(1'b1, 5, 2, "R10 more urgent preempts");
        do_ack();
        rd(3'd5, 32'h22, "R11 nested active");
        do_done(5);
        do_done(1);
        set_line(0, 1'b0);
        set_line(1, 1'b0);
        set_line(3, 1'b0);
        idle(2);
        rd(3'd5, 32'h0, "R11 done clears");
        req_is(1'b0, 0, 0, "R9 nothing pending");
        expect_obs(2, 32'h0, "R12 in_handler low", 3'd0);
        do_ack();
        rd(3'd5, 32'h0, "R11 ack without request ignored");

        // R8 cancel
        wr(3'd0, 32'd5);
        pulse_line(5);
        req_is(1'b1, 5, 2, "R8 before cancel");
        wr(3'd4, 32'h2);
        req_is(1'b1, 5, 2, "R8 bit0 clear no effect");
        wr(3'd4, 32'h1);
        req_is(1'b0, 0, 0, "R8 cancel clears");

        // R8 edge and cancel in the same cycle
        set_line(5, 1'b1);
        @(posedge clk);
        wr(3'd4, 32'h1);
        idle(1);
        req_is(1'b1, 5, 2, "R8 edge wins over cancel");
        wr(3'd4, 32'h1);
        idle(2);
        req_is(1'b0, 0, 0, "R7 held input no relatch");
        set_line(5, 1'b0);
        idle(2);

        idle(2);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule